// File: doc/BRIEF.md
# Mini-RISC Execute Unit

This block is the execute stage of a small 16-bit load/store processor. The surrounding pipeline supplies two 16-bit operands, a 3-bit opcode, a 2-bit shift mode and a 4-bit branch condition. The block produces the ALU result, the flag values that result implies, and a branch-taken decision. It keeps a 4-bit condition register (sign, zero, overflow, carry) and loads that register on an execute strobe.

The ALU does not see operand A directly. A single-position right shifter sits in front of it and can pass A through, shift it arithmetically, rotate it, or rotate it through the stored carry. The ALU adds, adds with carry, subtracts, subtracts with borrow, ANDs and ORs. For address and branch-target opcodes it adds the operands and leaves the flags alone.

The branch decision is taken from the stored condition register, so a branch tests the flags of the last arithmetic or logic instruction that executed. Moves and compares come from add and subtract when a zero operand is supplied or the result is discarded upstream.

Top module: `mrx_exec_unit`

## Requirements
- R1: Opcode 000 gives A'+B. Opcode 001 gives A'+B+C, where C is the stored carry flag. The carry output is the carry out of bit 15. A' is operand A after the shifter.
- R2: Opcode 010 gives A'+~B+1. Opcode 011 gives A'+~B+C. Carry is the carry out of that addition, so C=1 means no borrow.
- R3: Opcode 100 gives A'&B and opcode 101 gives A'|B. For both, V is 0 and C takes the shifter carry.
- R4: Shift mode 00 passes A unchanged with shifter carry 0. Mode 01 shifts A right arithmetically: bit 15 keeps A[15] and the shifter carry is A[0].
- R5: Shift mode 10 rotates A right: bit 15 becomes A[0] and the carry is A[0]. Mode 11 rotates through carry: bit 15 becomes the stored C and the carry is A[0].
- R6: N equals result bit 15. Z is 1 exactly when the result is zero.
- R7: For opcodes 000 to 011, V is 1 when both addends of the effective addition (A' and B, or A' and ~B) have the same sign and the sum has the other sign.
- R8: The flag output packs N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. When the strobe is high with opcode 000 to 101, the register loads the new flags on the clock edge.
- R9: The stored flags do not change when the strobe is low, or when the opcode is 110 (load/store) or 111 (branch).
- R10: With opcode 111, branch_taken_o follows the condition field, evaluated on the stored flags. Bit 0 of the field picks "term set" (1) or "term clear" (0). Bits 3:1 pick the term: 0 constant false (so 0000 is always and 0001 is never), 1 C|Z, 2 C, 3 Z, 4 V, 5 N, 6 N^V, 7 (N^V)|Z. For any other opcode branch_taken_o is 0.
- R11: After reset the stored flags are 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute strobe, enables a flag update |
| opcode_i | input | 3 | Operation code |
| shift_i | input | 2 | Shift mode applied to operand A |
| cond_i | input | 4 | Branch condition field |
| op_a_i | input | 16 | Operand A |
| op_b_i | input | 16 | Operand B |
| result_o | output | 16 | ALU result (combinational) |
| next_flags_o | output | 4 | Flags the current result implies, NZVC |
| flags_o | output | 4 | Stored condition register, NZVC |
| branch_taken_o | output | 1 | Branch decision for opcode 111 |

## Verification
The properties assume the opcode, condition and strobe inputs are stable and known at every rising edge. They also assume the carry-in used by ADC, SBC and rotate-through-carry is the flag value already stored. The stimulus changes every input only on falling edges and never leaves an input undriven after time zero. The bench keeps its own copy of the stored flags and advances it only on strobes that should update it. Its carry-dependent expectations therefore always match the state the design actually holds.

// File: rtl/mrx_pkg.sv
`timescale 1ns/1ps
package mrx_pkg;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned COND_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'b000,
    OP_ADC  = 3'b001,
    OP_SUB  = 3'b010,
    OP_SBC  = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_LDST = 3'b110,
    OP_BR   = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_ASR  = 2'b01,
    SH_ROR  = 2'b10,
    SH_RRC  = 2'b11
  } shift_e;

  // packed order gives n at bit 3 down to c at bit 0
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;
endpackage

// File: rtl/mrx_pre_shift.sv
`timescale 1ns/1ps
module mrx_pre_shift
  import mrx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [1:0]        mode_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] a_o,
  output logic              cout_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic top_bit;

  always_comb begin
    unique case (shift_e'(mode_i))
      SH_ASR:  top_bit = a_i[MSB];
      SH_ROR:  top_bit = a_i[0];
      SH_RRC:  top_bit = cin_i;
      default: top_bit = a_i[MSB];
    endcase
  end

  always_comb begin
    if (shift_e'(mode_i) == SH_NONE) begin
      a_o    = a_i;
      cout_o = 1'b0;
    end else begin
      a_o    = {top_bit, a_i[MSB:1]};
      cout_o = a_i[0];
    end
  end
endmodule

// File: rtl/mrx_alu.sv
`timescale 1ns/1ps
module mrx_alu
  import mrx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sh_cout_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output nzvc_t             flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  op_e              op;
  logic             invert_b;
  logic             carry_in;
  logic             is_logic;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum;

  assign op       = op_e'(opcode_i);
  assign invert_b = (op == OP_SUB) || (op == OP_SBC);
  assign is_logic = (op == OP_AND) || (op == OP_OR);
  assign b_eff    = invert_b ? ~b_i : b_i;

  always_comb begin
    unique case (op)
      OP_ADC, OP_SBC: carry_in = cin_i;
      OP_SUB:         carry_in = 1'b1;
      default:        carry_in = 1'b0;
    endcase
  end

  assign sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, carry_in};

  always_comb begin
    unique case (op)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      default: res_o = sum[MSB:0];
    endcase
  end

  always_comb begin
    flags_o.n = res_o[MSB];
    flags_o.z = ~|res_o;
    if (is_logic) begin
      flags_o.v = 1'b0;
      flags_o.c = sh_cout_i;
    end else begin
      flags_o.v = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);
      flags_o.c = sum[DATA_W];
    end
  end
endmodule

// File: rtl/mrx_cond_eval.sv
`timescale 1ns/1ps
module mrx_cond_eval
  import mrx_pkg::*;
(
  input  nzvc_t             flags_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              met_o
);
  localparam int unsigned TERMS = 1 << (COND_W - 1);

  logic [TERMS-1:0] term;
  logic             sel;

  assign term = {
    (flags_i.n ^ flags_i.v) | flags_i.z,
    flags_i.n ^ flags_i.v,
    flags_i.n,
    flags_i.v,
    flags_i.z,
    flags_i.c,
    flags_i.c | flags_i.z,
    1'b0
  };

  assign sel   = term[cond_i[COND_W-1:1]];
  // bit 0 picks "term set" versus "term clear"
  assign met_o = ~(sel ^ cond_i[0]);
endmodule

// File: rtl/mrx_exec_unit.sv
`timescale 1ns/1ps
module mrx_exec_unit
  import mrx_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  logic [2:0]        opcode_i,
  input  logic [1:0]        shift_i,
  input  logic [3:0]        cond_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        next_flags_o,
  output logic [3:0]        flags_o,
  output logic              branch_taken_o
);
  nzvc_t             flags_q;
  nzvc_t             flags_d;
  logic [DATA_W-1:0] a_shifted;
  logic              sh_cout;
  logic              cond_met;
  logic              writes_flags;

  mrx_pre_shift #(.DATA_W(DATA_W)) u_shift (
    .a_i    (op_a_i),
    .mode_i (shift_i),
    .cin_i  (flags_q.c),
    .a_o    (a_shifted),
    .cout_o (sh_cout)
  );

  mrx_alu #(.DATA_W(DATA_W)) u_alu (
    .opcode_i  (opcode_i),
    .a_i       (a_shifted),
    .b_i       (op_b_i),
    .sh_cout_i (sh_cout),
    .cin_i     (flags_q.c),
    .res_o     (result_o),
    .flags_o   (flags_d)
  );

  mrx_cond_eval u_cond (
    .flags_i (flags_q),
    .cond_i  (cond_i),
    .met_o   (cond_met)
  );

  assign writes_flags = exec_i && (opcode_i[2:1] != 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           flags_q <= '0;
    else if (writes_flags) flags_q <= flags_d;
  end

  assign next_flags_o   = flags_d;
  assign flags_o        = flags_q;
  assign branch_taken_o = (op_e'(opcode_i) == OP_BR) && cond_met;
endmodule

// File: rtl/mrx_exec_chk.sv
`timescale 1ns/1ps
module mrx_exec_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exec_i,
  input logic [2:0]        opcode_i,
  input logic [3:0]        cond_i,
  input logic [DATA_W-1:0] result_o,
  input logic [3:0]        next_flags_o,
  input logic [3:0]        flags_o,
  input logic              branch_taken_o
);
  // R8
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opcode_i[2:1] != 2'b11) |=> (flags_o == $past(next_flags_o)));

  // R9
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_i || opcode_i[2:1] == 2'b11) |=> $stable(flags_o));

  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_flags_o[2] == (result_o == '0));

  // R6
  sign_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_flags_o[3] == result_o[DATA_W-1]);

  // R3
  logic_no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 3'b100 || opcode_i == 3'b101) |-> !next_flags_o[1]);

  // R10
  br_always_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 3'b111 && cond_i == 4'b0000) |-> branch_taken_o);

  // R10
  br_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i != 3'b111 || cond_i == 4'b0001) |-> !branch_taken_o);
endmodule

bind mrx_exec_unit mrx_exec_chk #(.DATA_W(DATA_W)) u_exec_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .exec_i         (exec_i),
  .opcode_i       (opcode_i),
  .cond_i         (cond_i),
  .result_o       (result_o),
  .next_flags_o   (next_flags_o),
  .flags_o        (flags_o),
  .branch_taken_o (branch_taken_o)
);

// File: tb/mrx_exec_unit_tb.sv
`timescale 1ns/1ps
module mrx_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [2:0]  opcode = 3'b000;
  logic [1:0]  shift = 2'b00;
  logic [3:0]  cond = 4'b0000;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [15:0] result;
  logic [3:0]  next_flags;
  logic [3:0]  flags;
  logic        taken;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  logic [3:0] mflags = 4'h0;

  always #5 clk = ~clk;

  mrx_exec_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .opcode_i(opcode),
    .shift_i(shift), .cond_i(cond), .op_a_i(op_a), .op_b_i(op_b),
    .result_o(result), .next_flags_o(next_flags), .flags_o(flags),
    .branch_taken_o(taken)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: returns {result, nzvc}
  function automatic logic [19:0] model(input logic [2:0] op, input logic [1:0] sh,
                                        input logic [15:0] a, input logic [15:0] b,
                                        input logic [3:0] f);
    logic [15:0] as, bb, r;
    logic sc, ci, v, c;
    logic [16:0] s;
    case (sh)
      2'd0: begin as = a; sc = 1'b0; end
      2'd1: begin as = {a[15], a[15:1]}; sc = a[0]; end
      2'd2: begin as = {a[0], a[15:1]}; sc = a[0]; end
      default: begin as = {f[0], a[15:1]}; sc = a[0]; end
    endcase
    bb = (op == 3'd2 || op == 3'd3) ? ~b : b;
    case (op)
      3'd1, 3'd3: ci = f[0];
      3'd2:       ci = 1'b1;
      default:    ci = 1'b0;
    endcase
    s = 17'(as) + 17'(bb) + 17'(ci);
    if (op == 3'd4)      begin r = as & b; v = 1'b0; c = sc; end
    else if (op == 3'd5) begin r = as | b; v = 1'b0; c = sc; end
    else begin
      r = s[15:0];
      v = (as[15] == bb[15]) && (s[15] != as[15]);
      c = s[16];
    end
    return {r, r[15], (r == 16'h0), v, c};
  endfunction

  function automatic bit cond_model(input logic [3:0] cc, input logic [3:0] f);
    bit x;
    case (cc[3:1])
      3'd0: x = 1'b0;
      3'd1: x = f[0] | f[2];
      3'd2: x = f[0];
      3'd3: x = f[2];
      3'd4: x = f[1];
      3'd5: x = f[3];
      3'd6: x = f[3] ^ f[1];
      default: x = (f[3] ^ f[1]) | f[2];
    endcase
    return cc[0] ? x : !x;
  endfunction

  // one strobed instruction; checks result, implied flags, stored flags
  task automatic t_alu(input logic [2:0] op, input logic [1:0] sh,
                       input logic [15:0] a, input logic [15:0] b, input string req);
    logic [19:0] e;
    @(negedge clk);
    opcode = op; shift = sh; op_a = a; op_b = b; exec = 1'b1;
    #1;
    e = model(op, sh, a, b, mflags);
    chk(result == e[19:4], req, 32'(result), 32'(e[19:4]));
    chk(next_flags == e[3:0], {req, " R6/R7 flags"}, 32'(next_flags), 32'(e[3:0]));
    @(negedge clk);
    exec = 1'b0;
    if (op[2:1] != 2'b11) mflags = e[3:0];
    chk(flags == mflags, "R8 stored flags", 32'(flags), 32'(mflags));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(flags == 4'h0, "R11 reset flags", 32'(flags), 32'h0);
    rst_n = 1'b1;
    mflags = 4'h0;
    @(negedge clk);
    chk(flags == 4'h0, "R11 flags after release", 32'(flags), 32'h0);
  endtask

  task automatic t_arith();
    t_alu(3'd0, 2'd0, 16'h1234, 16'h0101, "R1 add");
    t_alu(3'd0, 2'd0, 16'h7fff, 16'h0001, "R1 add overflow");
    t_alu(3'd0, 2'd0, 16'hffff, 16'h0001, "R1 add wrap to zero");
    t_alu(3'd1, 2'd0, 16'h0001, 16'h0001, "R1 adc with C=1");
    t_alu(3'd2, 2'd0, 16'h0005, 16'h0005, "R2 sub equal");
    t_alu(3'd2, 2'd0, 16'h0003, 16'h0005, "R2 sub borrow");
    t_alu(3'd3, 2'd0, 16'h0010, 16'h0001, "R2 sbc with C=0");
    t_alu(3'd2, 2'd0, 16'h8000, 16'h0001, "R2 R7 sub signed overflow");
    t_alu(3'd3, 2'd0, 16'h0010, 16'h0001, "R2 sbc with C=1");
  endtask

  task automatic t_logic_shift();
    t_alu(3'd4, 2'd0, 16'hf0f0, 16'h3c3c, "R3 R4 and no shift");
    t_alu(3'd4, 2'd1, 16'h8001, 16'hffff, "R3 R4 and asr");
    t_alu(3'd5, 2'd2, 16'h0001, 16'h0000, "R3 R5 or ror");
    t_alu(3'd5, 2'd3, 16'h0002, 16'h0000, "R3 R5 or rrc C=1");
    t_alu(3'd5, 2'd3, 16'h0002, 16'h0000, "R3 R5 or rrc C=0");
    t_alu(3'd0, 2'd1, 16'h4002, 16'h0001, "R1 R4 add asr");
  endtask

  task automatic t_hold();
    t_alu(3'd2, 2'd0, 16'h0003, 16'h0005, "R2 set flags");
    t_alu(3'd6, 2'd0, 16'h0000, 16'h0000, "R9 ldst no update");
    t_alu(3'd7, 2'd0, 16'h7fff, 16'h0001, "R9 branch no update");
    @(negedge clk);
    opcode = 3'd0; op_a = 16'h0000; op_b = 16'h0000; exec = 1'b0;
    @(negedge clk);
    chk(flags == mflags, "R9 strobe low", 32'(flags), 32'(mflags));
  endtask

  task automatic t_branch_set(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op);
    t_alu(op, 2'd0, a, b, "R10 flag setup");
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      opcode = 3'd7; cond = 4'(c); exec = 1'b0;
      #1;
      chk(taken == cond_model(4'(c), mflags), "R10 branch table",
          32'(taken), 32'(cond_model(4'(c), mflags)));
    end
    @(negedge clk);
    opcode = 3'd0; cond = 4'd0;
    #1;
    chk(taken == 1'b0, "R10 non-branch opcode", 32'(taken), 32'h0);
  endtask

  task automatic t_branch();
    t_branch_set(16'h0005, 16'h0005, 3'd2);
    t_branch_set(16'h0003, 16'h0005, 3'd2);
    t_branch_set(16'h8000, 16'h0001, 3'd2);
    t_branch_set(16'h7fff, 16'h0001, 3'd0);
    t_branch_set(16'h0009, 16'h0002, 3'd2);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_logic_shift();
    t_hold();
    t_branch();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule